// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This controller sits beside the decode and execute stages of a five-stage in-order pipeline. For each ALU operand of the instruction in execute, it chooses where the operand comes from:
- the value read from the register file;
- the result now in the execute/memory pipeline register;
- the result now in the memory/writeback pipeline register.

When both later stages hold a result for the same register, the younger one wins. A stage is a valid producer only when its register-write enable is set and its destination is not register 0.

A load's data is not ready until the end of the memory stage. It therefore cannot be bypassed to the instruction right behind it. When the instruction in decode reads the destination of a load that is now in execute, the controller asks for one stall cycle. The program counter and the fetch/decode register hold, and a bubble goes into the decode/execute register.

The controller also covers the case of a producer three slots ahead. It flags each decode-stage source that the writeback stage is writing in the same cycle, so the register-file read returns the new value. All outputs are combinational functions of the current stage fields. The clock and reset feed only the embedded checks.

Top module: `hazard_unit`

## Requirements
- R1: Operand select encoding is 2'b00 for register file, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback result; with all inputs zero every select is 2'b00, every bypass flag is 0 and no stall is requested.
- R2: When the execute/memory stage has write enable set, a nonzero destination and that destination equals an execute source, that operand select is 2'b10.
- R3: When only the memory/writeback stage is a valid producer of an execute source, that operand select is 2'b01.
- R4: When both stages are valid producers of the same execute source, the select is 2'b10.
- R5: A stage whose write enable is low, or whose destination is register 0, never causes a bypass.
- R6: Operand A follows the first execute source (ex_rs_i) and operand B the second (ex_rt_i), independently of each other.
- R7: When execute holds a load (ex_load_i and ex_we_i set, ex_rd_i nonzero) whose destination equals id_rs_i or id_rt_i, pc_hold_o, ifid_hold_o and idex_bubble_o are all 1 in that cycle.
- R8: No stall is requested when the instruction in execute is not a load, has write enable low, targets register 0, or matches neither decode source.
- R9: id_byp_o bit 0 (for id_rs_i) and bit 1 (for id_rt_i) are 1 when the writeback stage has write enable set and a nonzero destination equal to that source; they are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for embedded checks |
| id_rs_i | input | AW | First source register of instruction in decode |
| id_rt_i | input | AW | Second source register of instruction in decode |
| ex_rs_i | input | AW | First source register of instruction in execute |
| ex_rt_i | input | AW | Second source register of instruction in execute |
| ex_rd_i | input | AW | Destination register of instruction in execute |
| ex_we_i | input | 1 | Register-write enable of instruction in execute |
| ex_load_i | input | 1 | Instruction in execute is a load |
| mem_rd_i | input | AW | Destination held in execute/memory register |
| mem_we_i | input | 1 | Write enable held in execute/memory register |
| wb_rd_i | input | AW | Destination held in memory/writeback register |
| wb_we_i | input | 1 | Write enable held in memory/writeback register |
| fwd_a_o | output | 2 | Source select for ALU operand A |
| fwd_b_o | output | 2 | Source select for ALU operand B |
| id_byp_o | output | 2 | Decode read bypass flags, bit 0 first source, bit 1 second |
| pc_hold_o | output | 1 | Hold the program counter |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| idex_bubble_o | output | 1 | Zero the control fields entering execute |

## Verification
The bench builds the controller with its default 5-bit register numbers. This brings both register 0 and register 31 within reach. Register 0 exercises the rule that it never bypasses or stalls. Register 31 shows that the comparators use the full width. Vectors put producers in each stage alone and in both stages at once. They split the two operands between different producers, and vary one condition at a time around the load interlock.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_select.sv
module hzd_fwd_select
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output fwd_sel_e      sel_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit, wb_hit;
  assign mem_hit = mem_we_i && (mem_rd_i != ZERO_REG) && (mem_rd_i == src_i);
  assign wb_hit  = wb_we_i  && (wb_rd_i  != ZERO_REG) && (wb_rd_i  == src_i);

  // younger producer first
  always_comb begin
    if (mem_hit)     sel_o = SEL_EXMEM;
    else if (wb_hit) sel_o = SEL_MEMWB;
    else             sel_o = SEL_RF;
  end

  a_r4_exmem_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && src_i != ZERO_REG && mem_rd_i == src_i) |-> sel_o == SEL_EXMEM);

  a_r3_memwb_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(mem_we_i && mem_rd_i == src_i) && wb_we_i && src_i != ZERO_REG && wb_rd_i == src_i)
      |-> sel_o == SEL_MEMWB);

  a_r5_no_fwd_r0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == ZERO_REG) |-> sel_o == SEL_RF);

  a_r5_no_fwd_wen_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_i && !wb_we_i) |-> sel_o == SEL_RF);
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  output logic          stall_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic load_live;
  assign load_live = ex_load_i && ex_we_i && (ex_rd_i != ZERO_REG);
  assign stall_o   = load_live && ((ex_rd_i == id_rs_i) || (ex_rd_i == id_rt_i));

  a_r8_stall_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_load_i && ex_we_i && ex_rd_i != ZERO_REG));

  a_r8_stall_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i != id_rs_i && ex_rd_i != id_rt_i) |-> !stall_o);
endmodule

// File: rtl/hzd_rf_bypass.sv
module hzd_rf_bypass #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSRC*AW-1:0] id_src_i,
  input  logic [AW-1:0]      wb_rd_i,
  input  logic               wb_we_i,
  output logic [NSRC-1:0]    byp_o
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic wb_live;
  assign wb_live = wb_we_i && (wb_rd_i != ZERO_REG);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign byp_o[g] = wb_live && (id_src_i[g*AW +: AW] == wb_rd_i);
  end

  a_r9_no_r0_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_rd_i == ZERO_REG || !wb_we_i) |-> byp_o == '0);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic [1:0]    id_byp_o,
  output logic          pc_hold_o,
  output logic          ifid_hold_o,
  output logic          idex_bubble_o
);
  localparam int NSRC = 2;
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [NSRC*AW-1:0] ex_src, id_src;
  fwd_sel_e           sel [NSRC];
  logic               stall;

  assign ex_src = {ex_rt_i, ex_rs_i};
  assign id_src = {id_rt_i, id_rs_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    hzd_fwd_select #(.AW(AW)) u_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (ex_src[g*AW +: AW]),
      .mem_rd_i(mem_rd_i),
      .mem_we_i(mem_we_i),
      .wb_rd_i (wb_rd_i),
      .wb_we_i (wb_we_i),
      .sel_o   (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hzd_load_use #(.AW(AW)) u_lu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .id_rs_i  (id_rs_i),
    .id_rt_i  (id_rt_i),
    .ex_rd_i  (ex_rd_i),
    .ex_we_i  (ex_we_i),
    .ex_load_i(ex_load_i),
    .stall_o  (stall)
  );

  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;

  hzd_rf_bypass #(.AW(AW), .NSRC(NSRC)) u_rfb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .id_src_i(id_src),
    .wb_rd_i (wb_rd_i),
    .wb_we_i (wb_we_i),
    .byp_o   (id_byp_o)
  );

  a_r7_bubble_on_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_load_i && ex_we_i && ex_rd_i != ZERO_REG && (ex_rd_i == id_rs_i || ex_rd_i == id_rt_i))
      |-> (pc_hold_o && ifid_hold_o && idex_bubble_o));

  a_r6_operand_independent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs_i != ex_rt_i && mem_we_i && mem_rd_i == ex_rs_i && ex_rs_i != ZERO_REG)
      |-> (fwd_a_o == 2'b10 && fwd_b_o != 2'b10));
endmodule

// File: tb/hazard_unit_tb.sv
`timescale 1ns/1ps
module hazard_unit_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_load, mem_we, wb_we;
  logic [1:0] fwd_a, fwd_b, id_byp;
  logic pc_hold, ifid_hold, idex_bubble;

  hazard_unit #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs_i(id_rs), .id_rt_i(id_rt),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_rd_i(ex_rd),
    .ex_we_i(ex_we), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .id_byp_o(id_byp),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold), .idex_bubble_o(idex_bubble)
  );

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic [1:0] byp;
    logic       stall;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic drive(input int irs, input int irt, input int xrs, input int xrt,
                       input int xrd, input bit xwe, input bit xld,
                       input int mrd, input bit mwe, input int wrd, input bit wwe,
                       input logic [1:0] ea, input logic [1:0] eb,
                       input logic [1:0] ebyp, input bit est, input string tag);
    exp_t e;
    @(negedge clk);
    id_rs = AW'(irs); id_rt = AW'(irt);
    ex_rs = AW'(xrs); ex_rt = AW'(xrt); ex_rd = AW'(xrd);
    ex_we = xwe; ex_load = xld;
    mem_rd = AW'(mrd); mem_we = mwe;
    wb_rd = AW'(wrd); wb_we = wwe;
    e.a = ea; e.b = eb; e.byp = ebyp; e.stall = est; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // monitor: sample mid-phase after each driven vector
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "fwd_a", fwd_a, e.a);
        cmp(e.tag, "fwd_b", fwd_b, e.b);
        cmp(e.tag, "id_byp", id_byp, e.byp);
        cmp(e.tag, "pc_hold", {1'b0, pc_hold}, {1'b0, e.stall});
        cmp(e.tag, "ifid_hold", {1'b0, ifid_hold}, {1'b0, e.stall});
        cmp(e.tag, "idex_bubble", {1'b0, idex_bubble}, {1'b0, e.stall});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset / idle state
    drive(0,0, 0,0,0,0,0, 0,0, 0,0, 2'b00,2'b00,2'b00,0, "R1 idle");
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // R2 execute/memory producer, operand A
    drive(0,0, 3,4,0,0,0, 3,1, 0,0, 2'b10,2'b00,2'b00,0, "R2 exmem A");
    // R2 full-width register number
    drive(0,0, 31,4,0,0,0, 31,1, 0,0, 2'b10,2'b00,2'b00,0, "R2 exmem r31");
    // R2/R6 operand B only
    drive(0,0, 4,7,0,0,0, 7,1, 0,0, 2'b00,2'b10,2'b00,0, "R6 exmem B");
    // R3 memory/writeback only
    drive(0,0, 9,4,0,0,0, 2,1, 9,1, 2'b01,2'b00,2'b00,0, "R3 memwb A");
    // R4 both match
    drive(0,0, 5,5,0,0,0, 5,1, 5,1, 2'b10,2'b10,2'b00,0, "R4 priority");
    // R5 write enables low
    drive(0,0, 6,6,0,0,0, 6,0, 6,0, 2'b00,2'b00,2'b00,0, "R5 wen low");
    // R5 register 0 never bypasses (also R9 r0)
    drive(0,0, 0,0,0,0,0, 0,1, 0,1, 2'b00,2'b00,2'b00,0, "R5 r0");
    // R6 split producers
    drive(0,0, 1,2,0,0,0, 1,1, 2,1, 2'b10,2'b01,2'b00,0, "R6 split");
    // R7 load-use via first decode source
    drive(8,3, 0,0,8,1,1, 0,0, 0,0, 2'b00,2'b00,2'b00,1, "R7 load rs");
    // R7 via second decode source
    drive(3,8, 0,0,8,1,1, 0,0, 0,0, 2'b00,2'b00,2'b00,1, "R7 load rt");
    // R8 not a load
    drive(8,8, 0,0,8,1,0, 0,0, 0,0, 2'b00,2'b00,2'b00,0, "R8 alu op");
    // R8 load to register 0
    drive(0,0, 0,0,0,1,1, 0,0, 0,0, 2'b00,2'b00,2'b00,0, "R8 load r0");
    // R8 load without match
    drive(9,10, 0,0,8,1,1, 0,0, 0,0, 2'b00,2'b00,2'b00,0, "R8 no match");
    // R8 load with write enable low
    drive(8,8, 0,0,8,0,1, 0,0, 0,0, 2'b00,2'b00,2'b00,0, "R8 wen low");
    // R9 decode bypass, first source only
    drive(12,13, 0,0,0,0,0, 0,0, 12,1, 2'b00,2'b00,2'b01,0, "R9 byp rs");
    // R9 both sources
    drive(12,12, 0,0,0,0,0, 0,0, 12,1, 2'b00,2'b00,2'b11,0, "R9 byp both");
    // R9 write enable low
    drive(12,12, 0,0,0,0,0, 0,0, 12,0, 2'b00,2'b00,2'b00,0, "R9 wen low");
    // R7 combined with forwarding of the older instruction
    drive(14,0, 14,2,14,1,1, 14,1, 2,1, 2'b10,2'b01,2'b00,1, "R7 with fwd");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule